// File: doc/BRIEF.md
# Four-Channel DMA Transfer Controller

The block moves data between peripherals and memory on behalf of four request lines. While it does not own the bus it is a slave: the host loads, for each channel, a 16-bit start address and a 16-bit cycle register. The cycle register holds the number of cycles minus one in its low 14 bits and a transfer type in its top two bits. The host also writes a mode byte that enables channels, and reads a status byte. An enabled channel that raises its request makes the block assert its bus request. Once the bus grant is seen, the block becomes the bus master and runs four-clock DMA cycles for the winning channel. In each cycle it drives the address, pulls that channel's acknowledge low, and pulses the read/write strobe pair that the transfer type selects.

The controller is built around a six-state machine. The states are IDLE (slave, host access allowed), REQ (bus request raised, waiting for grant), ADDR (address out), STRB (strobes asserted), HOLD (strobes held) and INC (address increment, count decrement). The transitions are: IDLE→REQ when any enabled channel requests. REQ→ADDR when grant is high and a request remains. REQ→IDLE when the requests vanish. ADDR→STRB→HOLD→INC unconditionally. INC→ADDR when a request remains and grant is still high. INC→REQ when a request remains but grant has dropped. INC→IDLE when no enabled channel requests. A channel whose final cycle completes disables itself and latches its terminal-count flag.

Top module: `dma4_ctrl`

## Requirements
- R1: After reset, bus request is low, all acknowledges are high, all four strobes are high, `tc` and `mark` are low, status reads 0 and every channel is disabled.
- R2: Register map. `reg_addr[4]`=0 selects a channel register: bits [3:2] give the channel, bit 1 selects address (0) or cycle register (1), and bit 0 selects the low (0) or high (1) byte. `reg_addr`=16 writes the mode byte (bit n enables channel n) and reads the status byte. Host writes take effect only in IDLE (when `hrq` is low) with `cs` high.
- R3: Bus request rises when an enabled channel raises its request. No acknowledge goes low while `hlda` is low.
- R4: Fixed priority: among enabled requesting channels, channel 0 wins and channel 3 loses. Arbitration happens at every cycle boundary.
- R5: Each DMA cycle lasts four clocks with the winner's acknowledge low and its current address on `addr_out`. Strobes are active only in the second and third clocks.
- R6: Type code 01 drives `io_rd_n` and `mem_wr_n` low. Code 10 drives `mem_rd_n` and `io_wr_n` low. Codes 00 and 11 drive no strobe.
- R7: After each cycle the channel address rises by one and the 14-bit count falls by one. The type bits are kept, and register readback shows the new values.
- R8: `tc` is high during the cycle whose count is 0. Completing it sets status bit n for that channel and clears its enable, so later requests from that channel are ignored.
- R9: Status bit 4 is set by any accepted channel-register write. Reading status clears bits 0–4.
- R10: `mark` is high during every cycle whose remaining count has its low 7 bits all ones, i.e. every 128th cycle counted back from the final one.
- R11: If no enabled channel requests at the end of a cycle, the block returns to IDLE and drops `hrq`. Remaining work resumes on a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| cs | input | 1 | Register port select |
| reg_addr | input | 5 | Register address |
| reg_wr | input | 1 | Register write strobe (one clock) |
| reg_rd | input | 1 | Register read strobe (one clock) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data |
| drq | input | 4 | Per-channel service requests |
| dack_n | output | 4 | Per-channel acknowledges, active low |
| hrq | output | 1 | Bus request |
| hlda | input | 1 | Bus grant |
| addr_out | output | 16 | Memory address during a cycle |
| mem_rd_n | output | 1 | Memory read strobe, active low |
| mem_wr_n | output | 1 | Memory write strobe, active low |
| io_rd_n | output | 1 | Peripheral read strobe, active low |
| io_wr_n | output | 1 | Peripheral write strobe, active low |
| tc | output | 1 | Final cycle of a block |
| mark | output | 1 | 128-cycle marker |

## Verification
The assertions check several rules on every clock. At most one acknowledge is low, and no acknowledge starts without a prior grant. The two memory strobes never overlap. The granted channel never has a higher-priority request pending. A terminal-count cycle always leaves its channel disabled and its status flag set. A cycle boundary with no enabled request always drops the bus request. The bench's scenarios show the rest. It checks the exact four-state strobe phasing per type code and the address and count progression read back through the register port. It also checks the grant order across all four channels, the marker positions over a 300-cycle block, the resumption after a request is withdrawn, and the clear-on-read status.

// File: rtl/dma4_pkg.sv
package dma4_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_REQ, S_ADDR, S_STRB, S_HOLD, S_INC
    } dma_state_t;

    typedef enum logic [1:0] {
        OP_VERIFY  = 2'b00,
        OP_TOMEM   = 2'b01,
        OP_FROMMEM = 2'b10,
        OP_BAD     = 2'b11
    } dma_op_t;
endpackage

// File: rtl/dma4_chan.sv
module dma4_chan #(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_we,
    input  logic [1:0]    host_sel,
    input  logic [7:0]    host_d,
    input  logic          step,
    output logic [15:0]   addr_q,
    output logic [CW+1:0] tcr_q
);
    localparam int TW = CW + 2;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            addr_q <= '0;
            tcr_q  <= '0;
        end else if (host_we) begin
            unique case (host_sel)
                2'b00: addr_q[7:0]    <= host_d;
                2'b01: addr_q[15:8]   <= host_d;
                2'b10: tcr_q[7:0]     <= host_d;
                2'b11: tcr_q[TW-1:8]  <= host_d[TW-9:0];
            endcase
        end else if (step) begin
            addr_q         <= addr_q + 16'd1;
            tcr_q[CW-1:0]  <= tcr_q[CW-1:0] - CW'(1);
        end
    end
endmodule

// File: rtl/dma4_prio.sv
module dma4_prio #(
    parameter int N = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         req,
    output logic [N-1:0]         grant,
    output logic [$clog2(N)-1:0] idx,
    output logic                 any
);
    localparam int IW = $clog2(N);

    always_comb begin
        grant = '0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                grant    = '0;
                grant[i] = 1'b1;
                idx      = IW'(i);
            end
        end
        any = |req;
    end

    assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant) && (any == (grant != '0)));

    for (genvar g = 0; g < N; g++) begin : g_chk
        assert_no_higher_R4: assert property (@(posedge clk) disable iff (rst)
            grant[g] |-> (req[g] && ((req & N'((1 << g) - 1)) == '0)));
    end
endmodule

// File: rtl/dma4_ctrl.sv
module dma4_ctrl
    import dma4_pkg::*;
#(
    parameter int NCH      = 4,
    parameter int CW       = 14,
    parameter int MARK_MOD = 128
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cs,
    input  logic [4:0]     reg_addr,
    input  logic           reg_wr,
    input  logic           reg_rd,
    input  logic [7:0]     wdata,
    output logic [7:0]     rdata,
    input  logic [NCH-1:0] drq,
    output logic [NCH-1:0] dack_n,
    output logic           hrq,
    input  logic           hlda,
    output logic [15:0]    addr_out,
    output logic           mem_rd_n,
    output logic           mem_wr_n,
    output logic           io_rd_n,
    output logic           io_wr_n,
    output logic           tc,
    output logic           mark
);
    localparam int CHW = $clog2(NCH);
    localparam int TW  = CW + 2;
    localparam int MW  = $clog2(MARK_MOD);

    dma_state_t       state_q, state_d;
    logic [CHW-1:0]   cur_q;
    logic [NCH-1:0]   en_q, tcf_q;
    logic             upd_q;

    logic [15:0]      addr_arr [NCH];
    logic [TW-1:0]    tcr_arr  [NCH];
    logic [NCH-1:0]   ch_we, step_v, tc_clear, req_v, grant;
    logic [CHW-1:0]   win;
    logic             any_req, host_ok, mode_we, stat_rd, cur_last;
    logic [CW-1:0]    cur_cnt;
    dma_op_t          cur_op;

    assign host_ok = cs && (state_q == S_IDLE);
    assign mode_we = host_ok && reg_wr && reg_addr[4];
    assign stat_rd = host_ok && reg_rd && reg_addr[4];
    assign cur_cnt = tcr_arr[cur_q][CW-1:0];
    assign cur_op  = dma_op_t'(tcr_arr[cur_q][TW-1:TW-2]);
    assign cur_last = (cur_cnt == '0);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign ch_we[g]    = host_ok && reg_wr && !reg_addr[4] && (reg_addr[2 +: CHW] == CHW'(g));
        assign step_v[g]   = (state_q == S_INC) && (cur_q == CHW'(g));
        assign tc_clear[g] = step_v[g] && cur_last;

        dma4_chan #(.CW(CW)) u_chan (
            .clk(clk), .rst(rst), .host_we(ch_we[g]), .host_sel(reg_addr[1:0]),
            .host_d(wdata), .step(step_v[g]), .addr_q(addr_arr[g]), .tcr_q(tcr_arr[g])
        );
    end

    assign req_v = drq & en_q & ~tc_clear;

    dma4_prio #(.N(NCH)) u_prio (
        .clk(clk), .rst(rst), .req(req_v), .grant(grant), .idx(win), .any(any_req)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (any_req) state_d = S_REQ;
            S_REQ:  if (!any_req) state_d = S_IDLE;
                    else if (hlda) state_d = S_ADDR;
            S_ADDR: state_d = S_STRB;
            S_STRB: state_d = S_HOLD;
            S_HOLD: state_d = S_INC;
            S_INC:  if (!any_req) state_d = S_IDLE;
                    else if (hlda) state_d = S_ADDR;
                    else state_d = S_REQ;
        endcase
    end

    // State register and control registers
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state_q <= S_IDLE;
            cur_q   <= '0;
            en_q    <= '0;
            tcf_q   <= '0;
            upd_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d == S_ADDR) cur_q <= win;
            if (mode_we) en_q <= wdata[NCH-1:0];
            else         en_q <= en_q & ~tc_clear;
            tcf_q <= (stat_rd ? '0 : tcf_q) | tc_clear;
            upd_q <= (|ch_we) || (upd_q && !stat_rd);
        end
    end

    // Outputs from state
    always_comb begin
        dack_n   = '1;
        addr_out = '0;
        mem_rd_n = 1'b1;
        mem_wr_n = 1'b1;
        io_rd_n  = 1'b1;
        io_wr_n  = 1'b1;
        tc       = 1'b0;
        mark     = 1'b0;
        hrq      = (state_q != S_IDLE);
        unique case (state_q)
            S_IDLE, S_REQ: ;
            S_ADDR, S_STRB, S_HOLD, S_INC: begin
                dack_n[cur_q] = 1'b0;
                addr_out      = addr_arr[cur_q];
                tc            = cur_last;
                mark          = (cur_cnt[MW-1:0] == {MW{1'b1}});
                if (state_q == S_STRB || state_q == S_HOLD) begin
                    if (cur_op == OP_TOMEM) begin
                        io_rd_n  = 1'b0;
                        mem_wr_n = 1'b0;
                    end else if (cur_op == OP_FROMMEM) begin
                        mem_rd_n = 1'b0;
                        io_wr_n  = 1'b0;
                    end
                end
            end
        endcase
    end

    // Register read port
    always_comb begin
        logic [15:0] word;
        logic [CHW-1:0] rch;
        rch  = reg_addr[2 +: CHW];
        word = reg_addr[1] ? 16'(tcr_arr[rch]) : addr_arr[rch];
        if (reg_addr[4]) rdata = 8'({upd_q, tcf_q});
        else             rdata = reg_addr[0] ? word[15:8] : word[7:0];
    end

    assert_dack_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~dack_n));
    assert_grant_first_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(dack_n != '1) |-> $past(hlda));
    assert_strobe_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(!mem_rd_n && !mem_wr_n) && !(!io_rd_n && !io_wr_n));
    assert_tc_inhibit_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_INC && tc) |=> (!en_q[$past(cur_q)] && tcf_q[$past(cur_q)]));
    assert_release_R11: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_INC && (drq & en_q) == '0) |=> !hrq);
    assert_mark_tc_R10: assert property (@(posedge clk) disable iff (rst)
        mark |-> (!tc && dack_n != '1));
endmodule

// File: tb/sim_dma4_ctrl.sv
module sim_dma4_ctrl;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst;
    logic cs = 0, reg_wr = 0, reg_rd = 0, hlda, hold_off = 0;
    logic [4:0] reg_addr = '0;
    logic [7:0] wdata = '0, rdata;
    logic [3:0] drq = '0, dack_n;
    logic hrq, mem_rd_n, mem_wr_n, io_rd_n, io_wr_n, tc, mark;
    logic [15:0] addr_out;

    int n_chk = 0, n_bad = 0;
    int exp_addr[4], exp_rem[4], exp_op[4], cyc_cnt[4];
    int mark_cnt = 0, seq_len = 0, pos = 0, prev_ch = -1;
    int seq_buf[64];
    logic [7:0] rb;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma4_ctrl u0 (
        .clk(clk), .rst(rst), .cs(cs), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .wdata(wdata), .rdata(rdata), .drq(drq), .dack_n(dack_n),
        .hrq(hrq), .hlda(hlda), .addr_out(addr_out), .mem_rd_n(mem_rd_n),
        .mem_wr_n(mem_wr_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .tc(tc), .mark(mark)
    );

    always @(posedge clk or posedge rst)
        if (rst) hlda <= 1'b0;
        else     hlda <= hrq & ~hold_off;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Cycle-level reference monitor
    always @(negedge clk) begin
        if (!rst && dack_n != 4'hF) begin
            int ch;
            bit strb;
            ch = 0;
            for (int i = 0; i < 4; i++) if (!dack_n[i]) ch = i;
            pos = (ch != prev_ch) ? 0 : (pos + 1) % 4;
            prev_ch = ch;
            check(hlda == 1'b1, "R3 ack without grant", hlda, 1);
            if (pos == 0) begin
                check(addr_out == 16'(exp_addr[ch]), "R5 address", addr_out, exp_addr[ch]);
                check(tc == (exp_rem[ch] == 0), "R8 tc", tc, exp_rem[ch] == 0);
                check(mark == (exp_rem[ch] % 128 == 127), "R10 mark", mark, exp_rem[ch] % 128 == 127);
                if (mark) mark_cnt++;
                if (seq_len < 64) seq_buf[seq_len] = ch;
                seq_len++;
                cyc_cnt[ch]++;
            end
            strb = (pos == 1 || pos == 2);
            check(mem_rd_n == !(strb && exp_op[ch] == 2) && io_wr_n == !(strb && exp_op[ch] == 2),
                  "R6 read-from-memory strobes", {mem_rd_n, io_wr_n}, pos);
            check(mem_wr_n == !(strb && exp_op[ch] == 1) && io_rd_n == !(strb && exp_op[ch] == 1),
                  "R6 write-to-memory strobes", {mem_wr_n, io_rd_n}, pos);
            if (pos == 3) begin
                exp_addr[ch] = (exp_addr[ch] + 1) & 16'hFFFF;
                exp_rem[ch]  = exp_rem[ch] - 1;
            end
        end else begin
            prev_ch = -1;
        end
    end

    task automatic host_wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); cs = 1; reg_wr = 1; reg_addr = a; wdata = d;
        @(negedge clk); cs = 0; reg_wr = 0;
    endtask

    task automatic host_rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); cs = 1; reg_rd = 1; reg_addr = a;
        #1 d = rdata;
        @(negedge clk); cs = 0; reg_rd = 0;
    endtask

    task automatic prog(input int ch, input logic [15:0] a, input int op, input int n);
        logic [15:0] t;
        t = {2'(op), 14'(n - 1)};
        host_wr(5'(ch * 4 + 0), a[7:0]);
        host_wr(5'(ch * 4 + 1), a[15:8]);
        host_wr(5'(ch * 4 + 2), t[7:0]);
        host_wr(5'(ch * 4 + 3), t[15:8]);
        exp_addr[ch] = a; exp_rem[ch] = n - 1; exp_op[ch] = op; cyc_cnt[ch] = 0;
    endtask

    task automatic wait_idle();
        repeat (4) @(negedge clk);
        for (int k = 0; k < 20000 && hrq; k++) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual 0x1 expected 0x0");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(!hrq && dack_n == 4'hF && tc == 0 && mark == 0, "R1 outputs", {hrq, dack_n}, 8'h0F);
        check({mem_rd_n, mem_wr_n, io_rd_n, io_wr_n} == 4'hF, "R1 strobes",
              {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}, 15);
        host_rd(5'd16, rb);
        check(rb == 8'h00, "R1 status", rb, 0);
        drq = 4'hF; repeat (5) @(negedge clk);
        check(!hrq, "R1 channels disabled", hrq, 0);
        drq = 4'h0;

        // R2 / R9 register map readback, update flag
        for (int c = 0; c < 4; c++) begin
            host_wr(5'(c * 4 + 0), 8'(8'hB0 + c));
            host_wr(5'(c * 4 + 1), 8'(8'hA0 + c * 17));
            host_wr(5'(c * 4 + 2), 8'(8'h10 + c));
            host_wr(5'(c * 4 + 3), 8'(8'h5C + c));
        end
        for (int c = 0; c < 4; c++) begin
            host_rd(5'(c * 4 + 0), rb); check(rb == 8'(8'hB0 + c), "R2 addr lo", rb, 8'hB0 + c);
            host_rd(5'(c * 4 + 1), rb); check(rb == 8'(8'hA0 + c * 17), "R2 addr hi", rb, 8'hA0 + c * 17);
            host_rd(5'(c * 4 + 2), rb); check(rb == 8'(8'h10 + c), "R2 count lo", rb, 8'h10 + c);
            host_rd(5'(c * 4 + 3), rb); check(rb == 8'(8'h5C + c), "R2 count hi", rb, 8'h5C + c);
        end
        host_rd(5'd16, rb); check(rb == 8'h10, "R9 update flag set", rb, 8'h10);
        host_rd(5'd16, rb); check(rb == 8'h00, "R9 cleared on read", rb, 0);

        // R5-R8 sweep of channel and type code
        for (int c = 0; c < 4; c++) begin
            for (int op = 0; op < 4; op++) begin
                int n;
                logic [15:0] a0, a1;
                n  = 1 + c + 2 * op;
                a0 = 16'(16'h10FC + c * 16'h1000 + op * 16'h0200);
                prog(c, a0, op, n);
                host_rd(5'd16, rb);
                host_wr(5'd16, 8'(1 << c));
                drq[c] = 1'b1;
                wait_idle();
                check(!hrq, "R11 released", hrq, 0);
                check(cyc_cnt[c] == n, "R5 cycle count", cyc_cnt[c], n);
                host_rd(5'd16, rb); check(rb == 8'(1 << c), "R8 status tc", rb, 1 << c);
                a1 = a0 + 16'(n);
                host_rd(5'(c * 4 + 0), rb); check(rb == a1[7:0], "R7 addr lo", rb, a1[7:0]);
                host_rd(5'(c * 4 + 1), rb); check(rb == a1[15:8], "R7 addr hi", rb, a1[15:8]);
                host_rd(5'(c * 4 + 2), rb); check(rb == 8'hFF, "R7 count lo", rb, 8'hFF);
                host_rd(5'(c * 4 + 3), rb); check(rb == 8'({2'(op), 6'h3F}), "R7 count hi", rb, {2'(op), 6'h3F});
                repeat (5) @(negedge clk);
                check(!hrq, "R8 inhibited after tc", hrq, 0);
                drq[c] = 1'b0;
            end
        end

        // R4 fixed priority across all channels
        for (int c = 0; c < 4; c++) prog(c, 16'(16'h4000 + c * 16'h100), 2, 2);
        host_rd(5'd16, rb);
        seq_len = 0;
        host_wr(5'd16, 8'h0F);
        drq = 4'hF;
        wait_idle();
        drq = 4'h0;
        check(seq_len == 8, "R4 cycle total", seq_len, 8);
        for (int k = 0; k < 8; k++) check(seq_buf[k] == k / 2, "R4 grant order", seq_buf[k], k / 2);
        host_rd(5'd16, rb); check(rb == 8'h0F, "R8 all flags", rb, 8'h0F);

        // R3 hold-off and R2 write ignored while requesting
        hold_off = 1'b1;
        prog(2, 16'h2000, 0, 3);
        host_rd(5'd16, rb);
        host_wr(5'd16, 8'h04);
        drq[2] = 1'b1;
        repeat (8) @(negedge clk);
        check(hrq && dack_n == 4'hF, "R3 wait for grant", {hrq, dack_n}, 8'h1F);
        host_wr(5'd8, 8'h55);
        hold_off = 1'b0;
        wait_idle();
        drq[2] = 1'b0;
        host_rd(5'd8, rb); check(rb == 8'h03, "R2 busy write ignored", rb, 3);
        host_rd(5'd16, rb); check(rb == 8'h04, "R2 no update while busy", rb, 4);

        // R10 marker over a long block
        mark_cnt = 0;
        prog(1, 16'h8000, 1, 300);
        host_rd(5'd16, rb);
        host_wr(5'd16, 8'h02);
        drq[1] = 1'b1;
        wait_idle();
        drq[1] = 1'b0;
        check(mark_cnt == 2, "R10 mark count", mark_cnt, 2);
        check(cyc_cnt[1] == 300, "R10 block length", cyc_cnt[1], 300);

        // R11 withdraw request and resume
        prog(3, 16'h3000, 1, 10);
        host_rd(5'd16, rb);
        host_wr(5'd16, 8'h08);
        drq[3] = 1'b1;
        for (int k = 0; k < 200 && cyc_cnt[3] < 2; k++) @(negedge clk);
        drq[3] = 1'b0;
        wait_idle();
        begin
            int done;
            done = cyc_cnt[3];
            check(!hrq && done < 10, "R11 stop on withdraw", done, 10);
            host_rd(5'd16, rb); check(rb == 8'h00, "R11 no tc yet", rb, 0);
            host_rd(5'd12, rb); check(rb == 8'(done), "R11 partial address", rb, done);
        end
        drq[3] = 1'b1;
        wait_idle();
        drq[3] = 1'b0;
        check(cyc_cnt[3] == 10, "R11 resumed to end", cyc_cnt[3], 10);
        host_rd(5'd16, rb); check(rb == 8'h08, "R11 final tc", rb, 8);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule